// File: doc/BRIEF.md
# Boot Strap Latch and CPU Reset Sequencer

This block governs how the processor comes out of reset. After the power-on reset is released, it captures seven boot-mode strap inputs once, through a synchronizer, at a fixed point in time. It keeps the captured values in a status register that has no write path. From that register it decodes three settings: the boot-device code, the initial I/O voltage mode and the route of the debug chain. Strap bit 4 chooses between two clock sources. When the bit is set, the PLL output drives the system clock. When it is clear, the reference clock passes straight through.

The primary CPU reset output stays asserted until two conditions hold. The straps must be captured, and every reset source must have been quiet for a minimum hold time. When the PLL is selected, the block also waits for PLL lock before it releases the CPU. A system reset can come from four sources other than power-on: an external pin, a debug request, a watchdog expiry and a software request. A system reset re-runs the sequencer but keeps the captured straps. A cause register records which source started the most recent reset.

Top module: `boot_reset_seq`

## Requirements
- R1: The strap status register loads at the 4th rising edge of `ref_clk` with `por_n` high. `strap_valid` is 0 before that edge and 1 from that edge onward, until the next power-on reset.
- R2: Once `strap_valid` is 1, `strap_status` does not change when `strap_in` changes or when a system reset occurs. Only a new power-on reset recaptures it.
- R3: Field decode: `boot_dev_sel` = status bits [2:0], `io_volt_mode` = status bit 3, `dbg_chain_sel` = status bits [6:5].
- R4: `pll_en` equals status bit 4.
- R5: `sys_clk` follows `ref_clk` when status bit 4 is 0, and follows `pll_clk` when it is 1.
- R6: `cpu0_rst_n` is 0 while `strap_valid` is 0. It is also 0 until 16 consecutive quiet edges have passed. With the PLL bypassed, it rises at the 20th rising edge after `por_n` is released.
- R7: With status bit 4 set, `cpu0_rst_n` stays 0 after the hold time for as long as `pll_lock` is 0. It rises at the first edge that samples `pll_lock` high. If lock is already high, this is the 21st edge after power-on release.
- R8: `dbg_rst_req`, `wdt_rst_req` and `sw_rst_req` are synchronous and active high. Any of them sampled high drives `cpu0_rst_n` to 0 at that edge. With the PLL bypassed, `cpu0_rst_n` rises 16 edges after the last edge on which a request was sampled high.
- R9: `ext_rst_n` is active low and passes through a two-flop synchronizer. With the PLL bypassed, `cpu0_rst_n` rises at the 18th edge after the pin returns high.
- R10: `rst_cause` encoding: 0 power-on, 1 pin, 2 debug, 3 watchdog, 4 software. Power-on reset sets it to 0. It keeps its value until another source is seen.
- R11: When sources are active on the same edge, the cause is chosen in the order pin, then watchdog, then debug, then software.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock, clocks all logic |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| strap_in | input | 7 | Boot-mode strap inputs |
| ext_rst_n | input | 1 | External system reset pin, active low, asynchronous |
| dbg_rst_req | input | 1 | Debug-requested system reset |
| wdt_rst_req | input | 1 | Watchdog-expiry system reset |
| sw_rst_req | input | 1 | Software-requested system reset |
| pll_clk | input | 1 | PLL output clock |
| pll_lock | input | 1 | PLL lock indication |
| strap_status | output | 7 | Captured strap values, read only |
| strap_valid | output | 1 | Straps have been captured |
| boot_dev_sel | output | 3 | Boot-device code |
| io_volt_mode | output | 1 | Initial I/O buffer voltage mode |
| dbg_chain_sel | output | 2 | Debug-chain route |
| pll_en | output | 1 | PLL enabled by strap |
| sys_clk | output | 1 | System clock, either PLL output or reference clock |
| rst_cause | output | 3 | Cause of the most recent reset |
| cpu0_rst_n | output | 1 | Primary CPU reset, active low |

## Verification
Each result is due at a known edge count. The strap capture is due four edges after power-on release. The CPU release is due 20 edges after power-on release in bypass, 21 with lock already present, 16 after the last synchronous request and 18 after the pin returns high. The reset cause is due at the first edge that sees the request, or two edges later for the pin. The bench drives inputs and samples outputs at falling edges and counts them exactly. It checks the output one edge before each release point as still asserted and at the release point as deasserted, so an off-by-one in any counter or synchronizer shows up.

// File: rtl/boot_rst_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the boot strap latch and reset sequencer.
// Assumes a fixed seven-bit strap group with the field layout below.
package boot_rst_pkg;
    localparam int STRAP_W       = 7;
    localparam int BOOT_DEV_LSB  = 0;
    localparam int BOOT_DEV_W    = 3;
    localparam int IO_VOLT_BIT   = 3;
    localparam int PLL_STRAP_BIT = 4;
    localparam int DBG_SEL_LSB   = 5;
    localparam int DBG_SEL_W     = 2;

    typedef enum logic [2:0] {
        CAUSE_POR = 3'd0,
        CAUSE_PIN = 3'd1,
        CAUSE_DBG = 3'd2,
        CAUSE_WDT = 3'd3,
        CAUSE_SW  = 3'd4
    } rst_cause_e;

    typedef enum logic [1:0] {
        SEQ_HOLD = 2'd0,
        SEQ_LOCK = 2'd1,
        SEQ_RUN  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/strap_latch.sv
`timescale 1ns/1ps
// Synchronizes the strap inputs and captures them once, SAMPLE_DLY edges
// after power-on reset release. Assumes straps are stable around the sample.
module strap_latch #(
    parameter int STRAP_W     = 7,
    parameter int SAMPLE_DLY  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STRAP_W-1:0] strap_in,
    output logic [STRAP_W-1:0] strap_q,
    output logic               valid
);
    localparam int CNT_W = $clog2(SAMPLE_DLY + 1);

    logic [STRAP_W-1:0] sync_q [SYNC_STAGES];
    logic [CNT_W-1:0]   cnt_q;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            // One synchronizer stage for the strap bus.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[g] <= '0;
                else if (g == 0) sync_q[g] <= strap_in;
                else sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    // Count edges after release and capture the synchronized straps once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            valid   <= 1'b0;
            strap_q <= '0;
        end else if (!valid) begin
            if (cnt_q == CNT_W'(SAMPLE_DLY - 1)) begin
                strap_q <= sync_q[SYNC_STAGES-1];
                valid   <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rst_src_arb.sv
`timescale 1ns/1ps
// Collects the non-power-on reset sources, synchronizes the external pin
// and records the cause by priority. Assumes the request inputs are synchronous.
module rst_src_arb
    import boot_rst_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_n,
    input  logic       dbg_req,
    input  logic       wdt_req,
    input  logic       sw_req,
    output logic       any_active,
    output rst_cause_e cause
);
    logic [SYNC_STAGES-1:0] pin_sr;
    logic                   pin_act;

    // Two-or-more flop synchronizer on the external pin; idles deasserted.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_sr <= '1;
        else        pin_sr <= {pin_sr[SYNC_STAGES-2:0], pin_n};
    end

    // Merge all system reset sources into one hold request.
    always_comb begin
        pin_act    = !pin_sr[SYNC_STAGES-1];
        any_active = pin_act || dbg_req || wdt_req || sw_req;
    end

    // Record the highest-priority active source; power-on clears to POR.
    always_ff @(posedge clk) begin
        if (!rst_n)       cause <= CAUSE_POR;
        else if (pin_act) cause <= CAUSE_PIN;
        else if (wdt_req) cause <= CAUSE_WDT;
        else if (dbg_req) cause <= CAUSE_DBG;
        else if (sw_req)  cause <= CAUSE_SW;
    end
endmodule

// File: rtl/rst_sequencer.sv
`timescale 1ns/1ps
// Holds the primary CPU in reset for MIN_HOLD quiet edges, then waits for
// PLL lock if the PLL is enabled. Assumes pll_en is stable once straps are valid.
module rst_sequencer
    import boot_rst_pkg::*;
#(
    parameter int MIN_HOLD = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic straps_ok,
    input  logic sys_active,
    input  logic pll_en,
    input  logic pll_lock,
    output logic cpu_rst_n
);
    localparam int CNT_W = $clog2(MIN_HOLD + 1);

    seq_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;

    // Release state machine: hold, optional lock wait, run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_HOLD;
            cnt_q   <= '0;
        end else if (!straps_ok || sys_active) begin
            state_q <= SEQ_HOLD;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                SEQ_HOLD: begin
                    if (cnt_q == CNT_W'(MIN_HOLD - 1)) begin
                        state_q <= pll_en ? SEQ_LOCK : SEQ_RUN;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                SEQ_LOCK: if (pll_lock) state_q <= SEQ_RUN;
                default:  state_q <= SEQ_RUN;
            endcase
        end
    end

    // The reset output is a decode of the registered state.
    assign cpu_rst_n = (state_q == SEQ_RUN);
endmodule

// File: rtl/boot_reset_seq.sv
`timescale 1ns/1ps
// Top of the boot strap latch and reset sequencer: captures straps, decodes
// them, selects the system clock and sequences the primary CPU reset.
// Assumes all logic runs on the reference clock.
module boot_reset_seq
    import boot_rst_pkg::*;
#(
    parameter int SAMPLE_DLY  = 4,
    parameter int SYNC_STAGES = 2,
    parameter int MIN_HOLD    = 16
) (
    input  logic               ref_clk,
    input  logic               por_n,
    input  logic [STRAP_W-1:0] strap_in,
    input  logic               ext_rst_n,
    input  logic               dbg_rst_req,
    input  logic               wdt_rst_req,
    input  logic               sw_rst_req,
    input  logic               pll_clk,
    input  logic               pll_lock,
    output logic [STRAP_W-1:0] strap_status,
    output logic               strap_valid,
    output logic [2:0]         boot_dev_sel,
    output logic               io_volt_mode,
    output logic [1:0]         dbg_chain_sel,
    output logic               pll_en,
    output logic               sys_clk,
    output logic [2:0]         rst_cause,
    output logic               cpu0_rst_n
);
    logic       sys_active;
    rst_cause_e cause;

    strap_latch #(
        .STRAP_W    (STRAP_W),
        .SAMPLE_DLY (SAMPLE_DLY),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_latch (
        .clk     (ref_clk),
        .rst_n   (por_n),
        .strap_in(strap_in),
        .strap_q (strap_status),
        .valid   (strap_valid)
    );

    rst_src_arb #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_arb (
        .clk       (ref_clk),
        .rst_n     (por_n),
        .pin_n     (ext_rst_n),
        .dbg_req   (dbg_rst_req),
        .wdt_req   (wdt_rst_req),
        .sw_req    (sw_rst_req),
        .any_active(sys_active),
        .cause     (cause)
    );

    rst_sequencer #(
        .MIN_HOLD(MIN_HOLD)
    ) u_seq (
        .clk       (ref_clk),
        .rst_n     (por_n),
        .straps_ok (strap_valid),
        .sys_active(sys_active),
        .pll_en    (pll_en),
        .pll_lock  (pll_lock),
        .cpu_rst_n (cpu0_rst_n)
    );

    // Field decode of the captured straps and the clock-source selection.
    always_comb begin
        boot_dev_sel  = strap_status[BOOT_DEV_LSB +: BOOT_DEV_W];
        io_volt_mode  = strap_status[IO_VOLT_BIT];
        dbg_chain_sel = strap_status[DBG_SEL_LSB +: DBG_SEL_W];
        pll_en        = strap_status[PLL_STRAP_BIT];
        sys_clk       = pll_en ? pll_clk : ref_clk;
        rst_cause     = cause;
    end
endmodule

// File: rtl/boot_reset_seq_chk.sv
`timescale 1ns/1ps
// Property checker for boot_reset_seq, attached by bind below.
module boot_reset_seq_chk (
    input logic       clk,
    input logic       por_n,
    input logic [6:0] strap_status,
    input logic       strap_valid,
    input logic       pll_en,
    input logic       pll_lock,
    input logic       dbg_req,
    input logic       wdt_req,
    input logic       sw_req,
    input logic       cpu0_rst_n
);
    // R1
    valid_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
        strap_valid |=> strap_valid);

    // R2
    strap_frozen_chk: assert property (@(posedge clk) disable iff (!por_n)
        (strap_valid && $past(strap_valid)) |-> $stable(strap_status));

    // R6
    cpu_held_chk: assert property (@(posedge clk) disable iff (!por_n)
        !strap_valid |-> !cpu0_rst_n);

    // R7
    lock_gate_chk: assert property (@(posedge clk) disable iff (!por_n)
        ($rose(cpu0_rst_n) && pll_en) |-> $past(pll_lock));

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (dbg_req || wdt_req || sw_req) |=> !cpu0_rst_n);

    // R8
    quiet_release_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(cpu0_rst_n) |-> $past(!(dbg_req || wdt_req || sw_req)));
endmodule

bind boot_reset_seq boot_reset_seq_chk u_chk (
    .clk         (ref_clk),
    .por_n       (por_n),
    .strap_status(strap_status),
    .strap_valid (strap_valid),
    .pll_en      (pll_en),
    .pll_lock    (pll_lock),
    .dbg_req     (dbg_rst_req),
    .wdt_req     (wdt_rst_req),
    .sw_req      (sw_rst_req),
    .cpu0_rst_n  (cpu0_rst_n)
);

// File: tb/boot_reset_seq_bench.sv
`timescale 1ns/1ps
module boot_reset_seq_bench;
    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic [6:0] strap_in = '0;
    logic       ext_rst_n = 1'b1;
    logic       dbg_rst_req = 1'b0;
    logic       wdt_rst_req = 1'b0;
    logic       sw_rst_req = 1'b0;
    logic       pll_clk = 1'b0;
    logic       pll_lock = 1'b1;
    logic [6:0] strap_status;
    logic       strap_valid;
    logic [2:0] boot_dev_sel;
    logic       io_volt_mode;
    logic [1:0] dbg_chain_sel;
    logic       pll_en;
    logic       sys_clk;
    logic [2:0] rst_cause;
    logic       cpu0_rst_n;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    boot_reset_seq u_boot_reset_seq (
        .ref_clk(clk), .por_n(por_n), .strap_in(strap_in), .ext_rst_n(ext_rst_n),
        .dbg_rst_req(dbg_rst_req), .wdt_rst_req(wdt_rst_req), .sw_rst_req(sw_rst_req),
        .pll_clk(pll_clk), .pll_lock(pll_lock), .strap_status(strap_status),
        .strap_valid(strap_valid), .boot_dev_sel(boot_dev_sel), .io_volt_mode(io_volt_mode),
        .dbg_chain_sel(dbg_chain_sel), .pll_en(pll_en), .sys_clk(sys_clk),
        .rst_cause(rst_cause), .cpu0_rst_n(cpu0_rst_n)
    );

    localparam logic [6:0] STRAP_TBL [6] = '{7'h00, 7'h15, 7'h6A, 7'h7F, 7'h10, 7'h4B};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    // Power-on reset with given straps; por_n released at a falling edge.
    task automatic do_por(input logic [6:0] s);
        @(negedge clk);
        por_n = 1'b0;
        strap_in = s;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One-cycle synchronous request pulse: 1 = dbg, 2 = wdt, 3 = sw.
    task automatic pulse_req(input int which);
        @(negedge clk);
        dbg_rst_req = (which == 1);
        wdt_rst_req = (which == 2);
        sw_rst_req  = (which == 3);
        @(negedge clk);
        dbg_rst_req = 1'b0;
        wdt_rst_req = 1'b0;
        sw_rst_req  = 1'b0;
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            finish_run();
        end
    end

    initial begin
        // Reset state while power-on reset is held.
        wait_neg(3);
        chk("R6 reset cpu", cpu0_rst_n, 0);
        chk("R1 reset valid", strap_valid, 0);
        chk("R10 reset cause", rst_cause, 0);
        chk("R2 reset status", strap_status, 0);

        // Table walk: capture timing, decode and release timing per strap set.
        for (int i = 0; i < 6; i++) begin
            logic [6:0] s;
            s = STRAP_TBL[i];
            do_por(s);
            wait_neg(3);
            chk("R1 not yet valid", strap_valid, 0);
            wait_neg(1);
            chk("R1 valid", strap_valid, 1);
            chk("R2 status", strap_status, s);
            chk("R3 boot dev", boot_dev_sel, s[2:0]);
            chk("R3 io volt", io_volt_mode, s[3]);
            chk("R3 debug route", dbg_chain_sel, s[6:5]);
            chk("R4 pll en", pll_en, s[4]);
            wait_neg(15);
            chk("R6 held at 19", cpu0_rst_n, 0);
            wait_neg(1);
            chk(s[4] ? "R7 held at 20" : "R6 release at 20", cpu0_rst_n, !s[4]);
            if (s[4]) begin
                wait_neg(1);
                chk("R7 release at 21", cpu0_rst_n, 1);
            end
            chk("R10 por cause", rst_cause, 0);
        end

        // PLL lock wait.
        pll_lock = 1'b0;
        do_por(7'h10);
        wait_neg(40);
        chk("R7 waits for lock", cpu0_rst_n, 0);
        pll_lock = 1'b1;
        wait_neg(1);
        chk("R7 release after lock", cpu0_rst_n, 1);
        // Clock selection with the PLL in use.
        pll_clk = 1'b1;
        #1 chk("R5 pll clk high", sys_clk, 1);
        pll_clk = 1'b0;
        #1 chk("R5 pll clk low", sys_clk, 0);

        // Bypass mode for the system reset tests.
        do_por(7'h0B);
        wait_neg(20);
        chk("R6 bypass running", cpu0_rst_n, 1);
        chk("R5 bypass clk low", sys_clk, clk);
        @(posedge clk);
        #2 chk("R5 bypass clk high", sys_clk, 1);

        // Watchdog pulse: cause and release 16 edges later.
        pulse_req(2);
        chk("R8 wdt holds cpu", cpu0_rst_n, 0);
        chk("R10 wdt cause", rst_cause, 3);
        wait_neg(15);
        chk("R8 held at 15", cpu0_rst_n, 0);
        wait_neg(1);
        chk("R8 release at 16", cpu0_rst_n, 1);

        // Software and debug causes; straps change meanwhile but stay latched.
        strap_in = 7'h55;
        pulse_req(3);
        chk("R10 sw cause", rst_cause, 4);
        chk("R8 sw holds cpu", cpu0_rst_n, 0);
        wait_neg(16);
        chk("R8 sw release", cpu0_rst_n, 1);
        chk("R2 status kept", strap_status, 7'h0B);
        pulse_req(1);
        chk("R10 dbg cause", rst_cause, 2);
        wait_neg(16);
        chk("R2 status kept dbg", strap_status, 7'h0B);

        // Pin reset through the synchronizer.
        @(negedge clk);
        ext_rst_n = 1'b0;
        wait_neg(4);
        chk("R9 pin holds cpu", cpu0_rst_n, 0);
        chk("R10 pin cause", rst_cause, 1);
        ext_rst_n = 1'b1;
        wait_neg(17);
        chk("R9 held at 17", cpu0_rst_n, 0);
        wait_neg(1);
        chk("R9 release at 18", cpu0_rst_n, 1);

        // Priority among simultaneous sources.
        @(negedge clk);
        dbg_rst_req = 1'b1; wdt_rst_req = 1'b1; sw_rst_req = 1'b1;
        @(negedge clk);
        chk("R11 wdt over dbg sw", rst_cause, 3);
        wdt_rst_req = 1'b0;
        @(negedge clk);
        chk("R11 dbg over sw", rst_cause, 2);
        dbg_rst_req = 1'b0; sw_rst_req = 1'b0;
        ext_rst_n = 1'b0; wdt_rst_req = 1'b1;
        wait_neg(4);
        chk("R11 pin over wdt", rst_cause, 1);
        ext_rst_n = 1'b1; wdt_rst_req = 1'b0;
        wait_neg(20);
        chk("R10 cause sticky", rst_cause, 1);

        // New power-on reset recaptures straps and clears cause.
        do_por(7'h55);
        wait_neg(4);
        chk("R2 recapture on por", strap_status, 7'h55);
        chk("R10 por clears cause", rst_cause, 0);

        done = 1'b1;
        finish_run();
    end
endmodule